// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Channel

This block drives one half-duplex serial line on which the local end always speaks first. Software loads a 9-bit command word into the transmit register. If the channel is enabled, the block sends the word as an asynchronous frame and raises its direction output while it drives the line. After the stop bit it releases the line and listens for the far end's reply. The reply is 9 or 12 bits long, chosen by a control bit, and is captured into a readable register.

Three events end an exchange: a good reply, a reply whose stop bit is low, and silence that lasts longer than a programmable number of bit periods. Each event sets a sticky flag, and each flag has its own interrupt enable. The bit rate comes from a one-cycle enable strobe supplied from outside. The line is sampled once per strobe, so every bit lasts exactly one strobe period.

Register map (2-bit address): 0 = control, 1 = transmit word, 2 = reply, 3 = status. Control bits: [0] channel enable, [1] 12-bit reply select, [2] data-available interrupt enable, [3] framing-error interrupt enable, [4] timeout interrupt enable, [15:8] timeout limit in bit periods. Status bits: [0] data available, [1] framing error, [2] timeout, [3] busy.

Top module: `cmdrsp_channel`

## Requirements
- R1: An idle line is high. A frame is one low start bit, then the 9 data bits LSB first, then one high stop bit. Each bit lasts one strobe period.
- R2: A write to address 1 starts a frame only when control bit 0 is set and the channel is not busy. With bit 0 clear, the line and the direction output do not change.
- R3: Control bit 1 selects the reply length: 0 means 9 bits, 1 means 12 bits. The reply is received LSB first into reply bits [11:0]. In 9-bit mode, bits [11:9] read as zero.
- R4: A read of address 2 returns the last good reply. A reply with a framing error does not overwrite it.
- R5: A reply with a high stop bit sets data available (status bit 0). The interrupt follows that flag when control bit 2 is set.
- R6: The direction output is 1 from the start of a frame until the end of its stop bit, and 0 at all other times.
- R7: A low reply stop bit sets the framing-error flag (status bit 1). The interrupt follows that flag when control bit 3 is set.
- R8: Let L be the value in control bits [15:8]. If no start bit is seen within L strobes after the line turns around, the timeout flag (status bit 2) is set on the L-th strobe and the channel goes idle. The interrupt follows that flag when control bit 4 is set.
- R9: A read of address 2 clears data available.
- R10: The framing-error and timeout flags stay set until 1 is written to status bit 1 or bit 2 at address 3.
- R11: A write to address 1 while the channel is busy is ignored. A read of address 1 still returns the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| bit_tick | input | 1 | One-cycle bit-rate enable |
| ser_in | input | 1 | Serial line input |
| ser_out | output | 1 | Serial line output |
| dir_tx | output | 1 | 1 while driving the line |
| rx_avail | output | 1 | Reply available flag |
| rx_ferr | output | 1 | Reply framing-error flag |
| rx_tmo | output | 1 | Reply timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
A scoreboard rebuilds every frame on the line from the strobe-sampled output and compares it with the words the driver queued. A wrong bit order, a missing start or stop bit, or a frame sent while disabled therefore shows up as a mismatch or as an unexpected frame. The timeout limit is probed one strobe early and exactly on time, which catches an off-by-one in the silence counter. A reply with a low stop bit is sent to confirm that the flag rises and the reply register is left alone. Further checks cover both reply lengths (zeroed upper bits in 9-bit mode), a second write during a busy exchange, and clearing by read or by write-one.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  localparam int TXW   = 9;           // transmit word width
  localparam int RPW   = 12;          // widest reply
  localparam int TMOW  = 8;           // timeout limit width
  localparam int REGW  = 16;          // register data width
  localparam int FRW   = TXW + 2;     // frame incl. start/stop
  localparam int IDXW  = $clog2(RPW);

  typedef enum logic [1:0] {R_IDLE, R_WAIT, R_DATA, R_STOP} rx_st_e;

  // Frame as shifted out LSB first: start(0), data, stop(1)
  function automatic logic [FRW-1:0] frame_of(logic [TXW-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic logic [IDXW-1:0] reply_len(logic twelve);
    return twelve ? IDXW'(RPW) : IDXW'(TXW);
  endfunction
endpackage

// File: rtl/cmdrsp_tx.sv
module cmdrsp_tx
  import cmdrsp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start,
  input  logic [TXW-1:0] data,
  output logic           busy,
  output logic           line,
  output logic           done
);
  localparam int CW = $clog2(FRW);

  logic [FRW-1:0] sh_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;
  assign done = busy_q && tick && (cnt_q == CW'(FRW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        sh_q   <= frame_of(data);
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (tick) begin
      sh_q <= {1'b1, sh_q[FRW-1:1]};
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdrsp_rx.sv
module cmdrsp_rx
  import cmdrsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            arm,
  input  logic            len12,
  input  logic [TMOW-1:0] limit,
  input  logic            line,
  output logic            busy,
  output logic [RPW-1:0]  data,
  output logic            ok,
  output logic            bad,
  output logic            tmo
);
  rx_st_e          st_q;
  logic [RPW-1:0]  sh_q;
  logic [IDXW-1:0] idx_q;
  logic [IDXW-1:0] len_q;
  logic [TMOW-1:0] cnt_q;

  assign busy = (st_q != R_IDLE);
  assign data = sh_q;
  assign ok   = (st_q == R_STOP) && tick && line;
  assign bad  = (st_q == R_STOP) && tick && !line;
  assign tmo  = (st_q == R_WAIT) && tick && line && (cnt_q == TMOW'(limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= R_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        R_IDLE: if (arm) begin
          st_q  <= R_WAIT;
          sh_q  <= '0;
          cnt_q <= '0;
          len_q <= reply_len(len12);
        end
        R_WAIT: if (tick) begin
          if (!line) begin
            st_q  <= R_DATA;
            idx_q <= '0;
          end else if (tmo) begin
            st_q <= R_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          sh_q[idx_q] <= line;
          if (idx_q == len_q - 1'b1) st_q <= R_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        default: if (tick) st_q <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdrsp_channel.sv
module cmdrsp_channel
  import cmdrsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [REGW-1:0] reg_wdata,
  output logic [REGW-1:0] reg_rdata,
  input  logic            bit_tick,
  input  logic            ser_in,
  output logic            ser_out,
  output logic            dir_tx,
  output logic            rx_avail,
  output logic            rx_ferr,
  output logic            rx_tmo,
  output logic            irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_TXD = 2'd1, A_RXD = 2'd2, A_STAT = 2'd3;

  logic [REGW-1:0] ctrl_q;
  logic [TXW-1:0]  txd_q;
  logic [RPW-1:0]  rxd_q;
  logic            avail_q, ferr_q, tmo_q;

  // named internal events
  logic ctrl_en, ie_av, ie_fe, ie_to;
  logic tx_busy, tx_done, tx_start, rx_busy, chan_busy;
  logic cap_ok, cap_bad, tmo_hit, wr_txd, rd_rxd, wr_stat;
  logic [RPW-1:0] rx_word;

  assign ctrl_en   = ctrl_q[0];
  assign ie_av     = ctrl_q[2];
  assign ie_fe     = ctrl_q[3];
  assign ie_to     = ctrl_q[4];
  assign chan_busy = tx_busy | rx_busy;
  assign wr_txd    = reg_wr && (reg_addr == A_TXD);
  assign rd_rxd    = reg_rd && (reg_addr == A_RXD);
  assign wr_stat   = reg_wr && (reg_addr == A_STAT);
  assign tx_start  = wr_txd && ctrl_en && !chan_busy;

  cmdrsp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(tx_start),
    .data(reg_wdata[TXW-1:0]), .busy(tx_busy), .line(ser_out), .done(tx_done)
  );

  cmdrsp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .arm(tx_done),
    .len12(ctrl_q[1]), .limit(ctrl_q[15:8]), .line(ser_in), .busy(rx_busy),
    .data(rx_word), .ok(cap_ok), .bad(cap_bad), .tmo(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= {TMOW'(16), 8'h00};
      txd_q   <= '0;
      rxd_q   <= '0;
      avail_q <= 1'b0;
      ferr_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (wr_txd && !chan_busy) txd_q <= reg_wdata[TXW-1:0];
      if (cap_ok) rxd_q <= rx_word;
      if (cap_ok) avail_q <= 1'b1;
      else if (rd_rxd) avail_q <= 1'b0;
      if (cap_bad) ferr_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) ferr_q <= 1'b0;
      if (tmo_hit) tmo_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) tmo_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_TXD:   reg_rdata = REGW'(txd_q);
      A_RXD:   reg_rdata = REGW'(rxd_q);
      default: reg_rdata = REGW'({chan_busy, tmo_q, ferr_q, avail_q});
    endcase
  end

  assign dir_tx   = tx_busy;
  assign rx_avail = avail_q;
  assign rx_ferr  = ferr_q;
  assign rx_tmo   = tmo_q;
  assign irq      = (avail_q & ie_av) | (ferr_q & ie_fe) | (tmo_q & ie_to);
endmodule

// File: rtl/cmdrsp_channel_chk.sv
module cmdrsp_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        bit_tick,
  input logic        ser_out,
  input logic        dir_tx,
  input logic        rx_avail,
  input logic        rx_ferr,
  input logic        rx_tmo,
  input logic        irq,
  input logic        ctrl_en,
  input logic        ie_av,
  input logic        cap_ok
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx |-> ser_out);

  assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_tx) |-> $past(reg_wr && reg_addr == 2'd1 && ctrl_en));

  assert_avail_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && ie_av) |-> irq);

  assert_dir_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && !bit_tick) |=> dir_tx);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !cap_ok) |=> !rx_avail);

  assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ferr && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> rx_ferr);

  assert_tmo_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tmo && !(reg_wr && reg_addr == 2'd3 && reg_wdata[2])) |=> rx_tmo);
endmodule

bind cmdrsp_channel cmdrsp_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bit_tick(bit_tick),
  .ser_out(ser_out), .dir_tx(dir_tx), .rx_avail(rx_avail), .rx_ferr(rx_ferr),
  .rx_tmo(rx_tmo), .irq(irq), .ctrl_en(ctrl_en), .ie_av(ie_av), .cap_ok(cap_ok)
);

// File: tb/test_cmdrsp_channel.sv
`timescale 1ns/1ps
module test_cmdrsp_channel;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic bit_tick = 0, ser_in = 1;
  logic ser_out, dir_tx, rx_avail, rx_ferr, rx_tmo, irq;

  int checks = 0, failures = 0;
  logic [8:0] exp_q[$];
  int tick_cnt = 0;

  always #5 clk = ~clk;

  cmdrsp_channel i_cmdrsp_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_tick(bit_tick), .ser_in(ser_in), .ser_out(ser_out), .dir_tx(dir_tx),
    .rx_avail(rx_avail), .rx_ferr(rx_ferr), .rx_tmo(rx_tmo), .irq(irq)
  );

  // strobe every 4 cycles, driven on the falling edge
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    bit_tick <= (tick_cnt == 3);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: rebuilds transmitted frames bit by bit
  initial begin
    logic [10:0] got;
    int n;
    n = 0;
    forever begin
      @(negedge clk); #3;
      if (bit_tick && dir_tx) begin
        got[n] = ser_out;
        n++;
        if (n == 11) begin
          n = 0;
          if (exp_q.size() == 0) begin
            check("R2 unexpected frame", {21'd0, got}, 32'hFFFFFFFF);
          end else begin
            logic [8:0] w;
            w = exp_q.pop_front();
            check("R1 frame start", {31'd0, got[0]}, 0);
            check("R1 frame data", {23'd0, got[9:1]}, {23'd0, w});
            check("R1 frame stop", {31'd0, got[10]}, 1);
          end
        end
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #3 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic send_cmd(logic [8:0] w);
    exp_q.push_back(w);
    wr(2'd1, {7'd0, w});
  endtask

  task automatic next_tick();
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic wait_turn();
    do @(negedge clk); while (dir_tx);
  endtask

  task automatic reply(logic [11:0] v, int len, logic stop);
    ser_in = 0; next_tick();
    for (int i = 0; i < len; i++) begin ser_in = v[i]; next_tick(); end
    ser_in = stop; next_tick();
    ser_in = 1;
  endtask

  function automatic logic [15:0] ctl(int lim, bit ito, bit ife, bit iav, bit r12, bit en);
    return {8'(lim), 3'd0, ito, ife, iav, r12, en};
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    check("R1 reset idle line", ser_out, 1);
    check("R6 reset dir", dir_tx, 0);
    check("R5 reset avail", rx_avail, 0);
    check("R5 reset irq", irq, 0);

    // R2: disabled channel does nothing
    wr(2'd0, ctl(10, 0, 0, 0, 0, 0));
    wr(2'd1, 16'h033);
    repeat (60) @(negedge clk);
    #3 check("R2 disabled dir", dir_tx, 0);
    check("R2 disabled line", ser_out, 1);

    // 9-bit reply
    wr(2'd0, ctl(10, 1, 1, 1, 0, 1));
    send_cmd(9'h1A5);
    #3 check("R6 dir during tx", dir_tx, 1);
    wait_turn();
    #1 check("R6 dir after stop", dir_tx, 0);
    reply(12'hEF3, 9, 1);
    #3 check("R5 avail set", rx_avail, 1);
    check("R5 irq from avail", irq, 1);
    rd(2'd2, d);
    check("R3 9-bit reply, upper zero", d, 16'h0F3);
    check("R4 reply readback", d[8:0], 9'h0F3);
    #3 check("R9 read clears avail", rx_avail, 0);
    check("R9 irq drops", irq, 0);

    // 12-bit reply
    wr(2'd0, ctl(10, 1, 1, 1, 1, 1));
    send_cmd(9'h05A);
    wait_turn();
    reply(12'hABC, 12, 1);
    rd(2'd2, d);
    check("R3 12-bit reply", d, 16'h0ABC);

    // framing error
    send_cmd(9'h1FF);
    wait_turn();
    reply(12'h123, 12, 0);
    #3 check("R7 ferr set", rx_ferr, 1);
    check("R7 irq from ferr", irq, 1);
    check("R4 no avail on bad frame", rx_avail, 0);
    rd(2'd2, d);
    check("R4 reply kept on bad frame", d, 16'h0ABC);
    repeat (20) @(negedge clk);
    #3 check("R10 ferr sticky", rx_ferr, 1);
    wr(2'd3, 16'h0004);
    #3 check("R10 ferr kept on other bit", rx_ferr, 1);
    wr(2'd3, 16'h0002);
    #3 check("R10 ferr cleared", rx_ferr, 0);

    // timeout at exactly L strobes
    wr(2'd0, ctl(5, 1, 0, 0, 0, 1));
    send_cmd(9'h100);
    wait_turn();
    for (int i = 0; i < 4; i++) next_tick();
    #3 check("R8 no timeout before L", rx_tmo, 0);
    next_tick();
    #3 check("R8 timeout at L", rx_tmo, 1);
    check("R8 irq from tmo", irq, 1);
    rd(2'd3, d);
    check("R8 idle after timeout", d[3], 0);
    wr(2'd3, 16'h0004);
    #3 check("R10 tmo cleared", rx_tmo, 0);

    // write while busy ignored
    wr(2'd0, ctl(3, 0, 0, 0, 0, 1));
    send_cmd(9'h055);
    wr(2'd1, 16'h01FF);
    rd(2'd1, d);
    check("R11 txdata kept while busy", d, 16'h0055);
    wait_turn();
    repeat (4) next_tick();
    #3 check("R11 exchange ended", rx_tmo, 1);
    repeat (60) @(negedge clk);
    check("R11 single frame sent", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule